// File: doc/BRIEF.md
# Configuration-Write Special-Cycle Forwarder

This block sits inside a bridge between an initiating bus and a target bus. It examines the address phase of each configuration write that arrives from the initiator and sorts it into one of three kinds. A qualifying write either becomes a special cycle on the target bus, or goes upstream unchanged as a Type 1 configuration write. Every other write is left alone.

An accepted write is run as a delayed transaction. The block retries the first attempt and keeps address, data and command in one pending entry. It then drives the cycle on the target side and waits for that cycle to finish. A special cycle is complete when the target side reports a master abort. An upstream forward is complete when the target side reports a normal completion. After that, the initiator's next attempt that matches the entry exactly is answered with TRDY#. If that attempt asks for more than one data transfer, the block also signals a disconnect.

Top module: `cfg_spcyc_fwd`

## Requirements
- R1: A write is ignored unless all of these hold: the command is 4'b1011, address bits [1:0] are 2'b01, bits [15:11] are 5'b11111 and bits [10:8] are 3'b111. An ignored write produces no retry, no TRDY and no target request.
- R2: When `dir_up`=0, bus field bits [23:16] equal `sec_bus` and register field bits [7:2] are zero, the write becomes a special cycle. On the target side the command is 4'b0001 and address and data are unchanged.
- R3: When `dir_up`=1, the bus field equals `pri_bus` and the register field is zero, the write becomes a special cycle with command 4'b0001.
- R4: When `dir_up`=1 and the bus field is below `sec_bus` or above `sub_bus`, the write is forwarded with command 4'b1011 and unchanged address and data. When `dir_up`=0, a write whose bus field is out of range is ignored.
- R5: When both the special-cycle test and the upstream range test match, the special cycle wins.
- R6: An accepted first attempt gets `resp_retry` in the cycle after its address phase. From that same cycle, `tgt_req` is held high until completion.
- R7: A special cycle completes only on `tgt_mabort`, and `tgt_done` has no effect on it. An upstream forward completes on `tgt_done`. `tgt_req` drops in the cycle after completion.
- R8: After completion, an attempt whose address, data and command all equal the entry gets `resp_trdy` in the next cycle and frees the entry. An attempt that differs in any of them gets `resp_retry`.
- R9: When the completing attempt has `req_multi` set, `resp_disc` is raised together with `resp_trdy`.
- R10: Synchronous reset clears the entry. While `rst` is high and in the cycle after it, `tgt_req`, `resp_retry`, `resp_trdy` and `resp_disc` are low.
- R11: While a transaction is pending, every new attempt is retried, and the entry and the target-side outputs stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Address phase of an initiator configuration attempt |
| req_addr | input | AW | Captured address |
| req_cmd | input | 4 | Captured command code |
| req_data | input | DW | Data of the single transfer |
| req_multi | input | 1 | Initiator requests more than one data transfer |
| dir_up | input | 1 | 1 = upstream, 0 = downstream |
| pri_bus | input | 8 | Primary bus number register |
| sec_bus | input | 8 | Secondary bus number register |
| sub_bus | input | 8 | Subordinate bus number register |
| tgt_done | input | 1 | Target-side normal completion strobe |
| tgt_mabort | input | 1 | Target-side master-abort strobe |
| tgt_req | output | 1 | Target-side cycle request |
| tgt_addr | output | AW | Target-side address |
| tgt_cmd | output | 4 | Target-side command |
| tgt_data | output | DW | Target-side data |
| resp_retry | output | 1 | Retry answer to the initiator |
| resp_trdy | output | 1 | TRDY answer to the initiator |
| resp_disc | output | 1 | Disconnect in the first data phase |

## Verification
Some properties are checked by the assertions on every cycle. Retry and TRDY never appear together, and a disconnect never appears without TRDY. An ignored write leaves the block quiet, an accepted write is retried while the target request rises, and the pending entry holds still until it is completed or released. Other behaviour can only be shown by the bench's scenarios. These are the field-by-field decode, the choice between special cycle and forward, the pass-through of address and data, the completion strobe that is ignored, and the exact comparison of a repeat attempt.

// File: rtl/cfgsc_pkg.sv
package cfgsc_pkg;

    localparam int BUS_W   = 8;
    localparam int BUS_LSB = 16;
    localparam int DEC_W   = 24;

    localparam logic [3:0] CMD_CFG_WR = 4'b1011;
    localparam logic [3:0] CMD_SPCYC  = 4'b0001;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PEND = 2'd1,
        ST_DONE = 2'd2
    } fwd_state_t;

    typedef enum logic [1:0] {
        CLS_NONE = 2'd0,
        CLS_SPEC = 2'd1,
        CLS_FWD  = 2'd2
    } fwd_class_t;

    typedef struct packed {
        logic [1:0] low;
        logic [5:0] regno;
        logic [2:0] func;
        logic [4:0] dev;
        logic [BUS_W-1:0] bus;
    } addr_fields_t;

    function automatic addr_fields_t split_addr(input logic [DEC_W-1:0] a);
        addr_fields_t f;
        f.low   = a[1:0];
        f.regno = a[7:2];
        f.func  = a[10:8];
        f.dev   = a[15:11];
        f.bus   = a[BUS_LSB +: BUS_W];
        return f;
    endfunction

    function automatic logic base_ok(input addr_fields_t f, input logic [3:0] cmd);
        return (cmd == CMD_CFG_WR) && (f.low == 2'b01) &&
               (f.dev == 5'b11111) && (f.func == 3'b111);
    endfunction

    function automatic logic out_of_range(input logic [BUS_W-1:0] bus,
                                          input logic [BUS_W-1:0] lo,
                                          input logic [BUS_W-1:0] hi);
        return (bus < lo) || (bus > hi);
    endfunction

endpackage

// File: rtl/cfgsc_classifier.sv
module cfgsc_classifier
    import cfgsc_pkg::*;
(
    input  logic [DEC_W-1:0] addr,
    input  logic [3:0]       cmd,
    input  logic             dir_up,
    input  logic [BUS_W-1:0] pri_bus,
    input  logic [BUS_W-1:0] sec_bus,
    input  logic [BUS_W-1:0] sub_bus,
    output fwd_class_t       cls
);
    addr_fields_t f;
    logic         base, spec_hit, fwd_hit;
    logic [BUS_W-1:0] spec_bus;

    always_comb begin
        f        = split_addr(addr);
        base     = base_ok(f, cmd);
        spec_bus = dir_up ? pri_bus : sec_bus;
        spec_hit = base && (f.regno == 6'd0) && (f.bus == spec_bus);
        fwd_hit  = base && dir_up && out_of_range(f.bus, sec_bus, sub_bus);
        if (spec_hit)      cls = CLS_SPEC;
        else if (fwd_hit)  cls = CLS_FWD;
        else               cls = CLS_NONE;
    end
endmodule

// File: rtl/cfgsc_entry.sv
module cfgsc_entry
    import cfgsc_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
)(
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          release_ent,
    input  fwd_class_t    in_cls,
    input  logic [AW-1:0] in_addr,
    input  logic [3:0]    in_cmd,
    input  logic [DW-1:0] in_data,
    output fwd_class_t    held_cls,
    output logic [AW-1:0] held_addr,
    output logic [3:0]    held_cmd,
    output logic [DW-1:0] held_data,
    output logic          match
);
    typedef struct packed {
        logic          valid;
        fwd_class_t    cls;
        logic [AW-1:0] addr;
        logic [3:0]    cmd;
        logic [DW-1:0] data;
    } entry_t;

    entry_t ent;

    always_ff @(posedge clk) begin
        if (rst) begin
            ent <= '{valid: 1'b0, cls: CLS_NONE, addr: '0, cmd: '0, data: '0};
        end else if (load) begin
            ent <= '{valid: 1'b1, cls: in_cls, addr: in_addr, cmd: in_cmd, data: in_data};
        end else if (release_ent) begin
            ent.valid <= 1'b0;
            ent.cls   <= CLS_NONE;
        end
    end

    always_comb begin
        held_cls  = ent.cls;
        held_addr = ent.addr;
        held_cmd  = ent.cmd;
        held_data = ent.data;
        match     = ent.valid && (in_addr == ent.addr) &&
                    (in_cmd == ent.cmd) && (in_data == ent.data);
    end

    p_entry_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (ent.valid && !load && !release_ent) |=> $stable(ent));
endmodule

// File: rtl/cfgsc_fsm.sv
module cfgsc_fsm
    import cfgsc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  logic       req_multi,
    input  fwd_class_t new_cls,
    input  fwd_class_t held_cls,
    input  logic       match,
    input  logic       tgt_done,
    input  logic       tgt_mabort,
    output logic       load,
    output logic       release_ent,
    output logic       tgt_req,
    output logic       resp_retry,
    output logic       resp_trdy,
    output logic       resp_disc
);
    fwd_state_t state, state_nx;
    logic       complete, busy_retry;

    always_comb begin
        load        = req_valid && (state == ST_IDLE) && (new_cls != CLS_NONE);
        complete    = (state == ST_PEND) &&
                      ((held_cls == CLS_SPEC) ? tgt_mabort : tgt_done);
        release_ent = req_valid && (state == ST_DONE) && match;
        busy_retry  = req_valid && ((state == ST_PEND) ||
                                    ((state == ST_DONE) && !match));
        tgt_req     = (state == ST_PEND);
        state_nx    = state;
        case (state)
            ST_IDLE: if (load)        state_nx = ST_PEND;
            ST_PEND: if (complete)    state_nx = ST_DONE;
            ST_DONE: if (release_ent) state_nx = ST_IDLE;
            default:                  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            resp_retry <= 1'b0;
            resp_trdy  <= 1'b0;
            resp_disc  <= 1'b0;
        end else begin
            state      <= state_nx;
            resp_retry <= load || busy_retry;
            resp_trdy  <= release_ent;
            resp_disc  <= release_ent && req_multi;
        end
    end

    p_ignored_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && req_valid && new_cls == CLS_NONE)
        |=> (!resp_retry && !resp_trdy && !tgt_req));
    p_accept_retry_r6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && req_valid && new_cls != CLS_NONE)
        |=> (resp_retry && tgt_req));
    p_resp_excl_r8: assert property (@(posedge clk) disable iff (rst)
        !(resp_retry && resp_trdy));
    p_trdy_after_done_r8: assert property (@(posedge clk) disable iff (rst)
        resp_trdy |-> ($past(state) == ST_DONE && state == ST_IDLE));
    p_disc_with_trdy_r9: assert property (@(posedge clk) disable iff (rst)
        resp_disc |-> resp_trdy);
endmodule

// File: rtl/cfg_spcyc_fwd.sv
module cfg_spcyc_fwd
    import cfgsc_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
)(
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    input  logic [3:0]    req_cmd,
    input  logic [DW-1:0] req_data,
    input  logic          req_multi,
    input  logic          dir_up,
    input  logic [7:0]    pri_bus,
    input  logic [7:0]    sec_bus,
    input  logic [7:0]    sub_bus,
    input  logic          tgt_done,
    input  logic          tgt_mabort,
    output logic          tgt_req,
    output logic [AW-1:0] tgt_addr,
    output logic [3:0]    tgt_cmd,
    output logic [DW-1:0] tgt_data,
    output logic          resp_retry,
    output logic          resp_trdy,
    output logic          resp_disc
);
    fwd_class_t new_cls, held_cls;
    logic       load, release_ent, match;
    logic [3:0] held_cmd;

    cfgsc_classifier u_cls (
        .addr    (req_addr[DEC_W-1:0]),
        .cmd     (req_cmd),
        .dir_up  (dir_up),
        .pri_bus (pri_bus),
        .sec_bus (sec_bus),
        .sub_bus (sub_bus),
        .cls     (new_cls)
    );

    cfgsc_entry #(.AW(AW), .DW(DW)) u_ent (
        .clk         (clk),
        .rst         (rst),
        .load        (load),
        .release_ent (release_ent),
        .in_cls      (new_cls),
        .in_addr     (req_addr),
        .in_cmd      (req_cmd),
        .in_data     (req_data),
        .held_cls    (held_cls),
        .held_addr   (tgt_addr),
        .held_cmd    (held_cmd),
        .held_data   (tgt_data),
        .match       (match)
    );

    cfgsc_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_multi   (req_multi),
        .new_cls     (new_cls),
        .held_cls    (held_cls),
        .match       (match),
        .tgt_done    (tgt_done),
        .tgt_mabort  (tgt_mabort),
        .load        (load),
        .release_ent (release_ent),
        .tgt_req     (tgt_req),
        .resp_retry  (resp_retry),
        .resp_trdy   (resp_trdy),
        .resp_disc   (resp_disc)
    );

    assign tgt_cmd = (held_cls == CLS_SPEC) ? CMD_SPCYC : held_cmd;

    p_tgt_cmd_legal_r2: assert property (@(posedge clk) disable iff (rst)
        tgt_req |-> (tgt_cmd == CMD_SPCYC || tgt_cmd == CMD_CFG_WR));
    p_tgt_stable_r11: assert property (@(posedge clk) disable iff (rst)
        (tgt_req && $past(tgt_req)) |-> ($stable(tgt_addr) && $stable(tgt_data)));
endmodule

// File: tb/tb_cfg_spcyc_fwd.sv
`timescale 1ns/1ps
module tb_cfg_spcyc_fwd;
    localparam int AW = 32;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst;
    logic          req_valid, req_multi, dir_up;
    logic [AW-1:0] req_addr;
    logic [3:0]    req_cmd;
    logic [DW-1:0] req_data;
    logic [7:0]    pri_bus, sec_bus, sub_bus;
    logic          tgt_done, tgt_mabort;
    logic          tgt_req, resp_retry, resp_trdy, resp_disc;
    logic [AW-1:0] tgt_addr;
    logic [3:0]    tgt_cmd;
    logic [DW-1:0] tgt_data;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    cfg_spcyc_fwd #(.AW(AW), .DW(DW)) dut (.*);

    function automatic logic [31:0] mk(input logic [7:0] bus, input logic [4:0] dev,
                                       input logic [2:0] fn, input logic [5:0] rg,
                                       input logic [1:0] lo);
        return {8'h00, bus, dev, fn, rg, lo};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic attempt(input logic [31:0] a, input logic [3:0] c,
                           input logic [31:0] d, input logic multi);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_cmd = c; req_data = d; req_multi = multi;
        @(negedge clk);
        req_valid = 1'b0; req_multi = 1'b0;
    endtask

    task automatic strobe(input logic mab, input logic dn);
        @(negedge clk);
        tgt_mabort = mab; tgt_done = dn;
        @(negedge clk);
        tgt_mabort = 1'b0; tgt_done = 1'b0;
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R10 tgt_req", tgt_req, 0);
        chk("R10 resp", {resp_retry, resp_trdy, resp_disc}, 0);
    endtask

    task automatic t_ignored;
        logic [31:0] bad [5];
        logic [3:0]  cm  [5];
        bad[0] = mk(8'h05, 5'h1f, 3'h7, 6'h0, 2'b00); cm[0] = 4'b1011;
        bad[1] = mk(8'h05, 5'h1e, 3'h7, 6'h0, 2'b01); cm[1] = 4'b1011;
        bad[2] = mk(8'h05, 5'h1f, 3'h6, 6'h0, 2'b01); cm[2] = 4'b1011;
        bad[3] = mk(8'h05, 5'h1f, 3'h7, 6'h0, 2'b01); cm[3] = 4'b1010;
        bad[4] = mk(8'h05, 5'h1f, 3'h7, 6'h0, 2'b01); cm[4] = 4'b0001;
        dir_up = 1'b0;
        for (int i = 0; i < 5; i++) begin
            attempt(bad[i], cm[i], 32'h1234_0000 + i, 1'b0);
            chk("R1 no response", {resp_retry, resp_trdy}, 0);
            chk("R1 no tgt_req", tgt_req, 0);
        end
    endtask

    task automatic run_full(input string tag, input logic up, input logic [31:0] a,
                            input logic [31:0] d, input logic [3:0] exp_cmd,
                            input logic spec);
        dir_up = up;
        attempt(a, 4'b1011, d, 1'b0);
        chk({tag, " R6 first retry"}, resp_retry, 1);
        chk({tag, " R6 tgt_req"}, tgt_req, 1);
        chk({tag, " tgt_cmd"}, tgt_cmd, exp_cmd);
        chk({tag, " tgt_addr"}, tgt_addr, a);
        chk({tag, " tgt_data"}, tgt_data, d);
        if (spec) begin
            strobe(1'b0, 1'b1);
            chk({tag, " R7 done ignored"}, tgt_req, 1);
            strobe(1'b1, 1'b0);
        end else begin
            strobe(1'b0, 1'b1);
        end
        chk({tag, " R7 completion"}, tgt_req, 0);
        attempt(a, 4'b1011, d, 1'b0);
        chk({tag, " R8 trdy"}, {resp_trdy, resp_retry, resp_disc}, 3'b100);
    endtask

    task automatic t_down_special;
        run_full("R2", 1'b0, mk(8'h05, 5'h1f, 3'h7, 6'h0, 2'b01), 32'hA5A5_0001, 4'b0001, 1'b1);
    endtask

    task automatic t_up_special;
        run_full("R3", 1'b1, mk(8'h00, 5'h1f, 3'h7, 6'h0, 2'b01), 32'h5A5A_0002, 4'b0001, 1'b1);
    endtask

    task automatic t_up_forward;
        run_full("R4", 1'b1, mk(8'h20, 5'h1f, 3'h7, 6'h3, 2'b01), 32'hC0DE_0003, 4'b1011, 1'b0);
        dir_up = 1'b0;
        attempt(mk(8'h20, 5'h1f, 3'h7, 6'h0, 2'b01), 4'b1011, 32'h0, 1'b0);
        chk("R4 downstream out of range ignored", {resp_retry, tgt_req}, 0);
        dir_up = 1'b1;
        attempt(mk(8'h06, 5'h1f, 3'h7, 6'h0, 2'b01), 4'b1011, 32'h0, 1'b0);
        chk("R4 upstream in range ignored", {resp_retry, tgt_req}, 0);
    endtask

    task automatic t_priority;
        pri_bus = 8'h01;
        run_full("R5", 1'b1, mk(8'h01, 5'h1f, 3'h7, 6'h0, 2'b01), 32'hBEEF_0004, 4'b0001, 1'b1);
        pri_bus = 8'h00;
    endtask

    task automatic t_pending_and_mismatch;
        logic [31:0] a, b;
        a = mk(8'h05, 5'h1f, 3'h7, 6'h0, 2'b01);
        b = mk(8'h05, 5'h1f, 3'h7, 6'h0, 2'b01);
        dir_up = 1'b0;
        attempt(a, 4'b1011, 32'h1111_1111, 1'b0);
        attempt(b, 4'b1011, 32'h2222_2222, 1'b0);
        chk("R11 pending retry", {resp_retry, resp_trdy}, 2'b10);
        chk("R11 entry kept", tgt_data, 32'h1111_1111);
        chk("R11 still requesting", tgt_req, 1);
        strobe(1'b1, 1'b0);
        attempt(a, 4'b1011, 32'h1111_1112, 1'b0);
        chk("R8 data mismatch retry", {resp_retry, resp_trdy}, 2'b10);
        attempt(a ^ 32'h0001_0000, 4'b1011, 32'h1111_1111, 1'b0);
        chk("R8 addr mismatch retry", {resp_retry, resp_trdy}, 2'b10);
        attempt(a, 4'b1111, 32'h1111_1111, 1'b0);
        chk("R8 cmd mismatch retry", {resp_retry, resp_trdy}, 2'b10);
        attempt(a, 4'b1011, 32'h1111_1111, 1'b1);
        chk("R9 disconnect with trdy", {resp_trdy, resp_disc, resp_retry}, 3'b110);
        @(negedge clk);
        chk("R8 entry freed", {tgt_req, resp_trdy}, 0);
    endtask

    task automatic t_reset_clears;
        dir_up = 1'b0;
        attempt(mk(8'h05, 5'h1f, 3'h7, 6'h0, 2'b01), 4'b1011, 32'h7, 1'b0);
        chk("R10 pre-reset pending", tgt_req, 1);
        t_reset();
    endtask

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_multi = 1'b0; dir_up = 1'b0;
        req_addr = '0; req_cmd = '0; req_data = '0;
        pri_bus = 8'h00; sec_bus = 8'h05; sub_bus = 8'h0A;
        tgt_done = 1'b0; tgt_mabort = 1'b0;
        t_reset();
        t_ignored();
        t_down_special();
        t_up_special();
        t_up_forward();
        t_priority();
        t_pending_and_mismatch();
        t_reset_clears();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #50000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule